// File: doc/BRIEF.md
# Push-Button Power Sequencer

This block decides whether an interface device is powered, driven by a single momentary switch that pulls its input to ground while it is held. The raw switch level is synchronised and filtered. A closure counts as a press only after it has stayed stable for a programmable number of clock cycles. The block behaves the same whether the input comes from a bouncing mechanical contact or from a clean logic output of a host controller.

While the device is off, a press enables power straight away. While the device is on, a press does not cut power. It raises a shutdown request to the host, and the block then waits for the host's acknowledge. After the acknowledge, it asks the card side to run its deactivation sequence. Power is removed only when that sequence reports completion, and at that moment the shutdown request is cleared as well. A system without host involvement can tie the acknowledge to the request output, and the device then shuts itself down on its own.

Top module: `pwrbtn_ctrl`

## Requirements
- R1: After reset, powerEn, offReq and deactReq are all low and the controller is off.
- R2: switchN is active low. A low level counts as a press only after it has been held for DEBOUNCE_CYCLES consecutive clocks, after a two-stage input synchroniser. Any return to high restarts the count, so a burst of low pulses each shorter than the period is ignored. The earliest output response is no sooner than DEBOUNCE_CYCLES clocks after the input falls.
- R3: A press while off sets powerEn high and leaves offReq and deactReq low.
- R4: A press while on raises offReq and keeps powerEn high.
- R5: offAck high while offReq is pending raises deactReq on the next clock edge. powerEn and offReq stay high until deactivation completes.
- R6: deactDone high while deactReq is high drives powerEn, offReq and deactReq low on the next clock edge, and the controller is off again.
- R7: With offAck tied to offReq, a press while on runs the whole shutdown to deactReq without any host action.
- R8: Holding the switch low produces a single press. A new press is accepted only after the switch has been seen released for a full debounce period, so a release glitch shorter than the period produces no second press.
- R9: A press while offReq is pending, offAck while no request is pending, and deactDone while no deactivation is requested each leave all three outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| switchN | input | 1 | Raw push switch, low while pressed |
| offAck | input | 1 | Host acknowledge of the shutdown request |
| deactDone | input | 1 | Card deactivation sequence has finished |
| powerEn | output | 1 | Enable for the device's powered functions |
| offReq | output | 1 | Shutdown request to the host |
| deactReq | output | 1 | Request to start card deactivation |

## Verification
The bench targets bounce bursts whose pulses each fall just short of the debounce period. A filter that accumulated across bounces instead of restarting would power the device up on noise. A long hold with a brief release glitch is also applied, because a controller that re-armed too early would turn a single hold into an on-then-off toggle. Presses, acknowledges and completion pulses are injected in the wrong states, where a loosely decoded controller would drop power before deactivation completed or leave the request stuck high. The tied-acknowledge case confirms that the shutdown completes without a host and without a combinational loop.

// File: rtl/pwrbtn_pkg.sv
package pwrbtn_pkg;

  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_ON    = 2'd1,
    ST_REQ   = 2'd2,
    ST_DEACT = 2'd3
  } pwrState_t;

  typedef struct packed {
    logic setPower;
    logic setOffReq;
    logic setDeact;
    logic clrAll;
  } pwrStrobe_t;

endpackage

// File: rtl/pwrbtn_datapath.sv
module pwrbtn_datapath
  import pwrbtn_pkg::*;
#(
  parameter int DEBOUNCE_CYCLES = 1024,
  parameter int SYNC_STAGES     = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       switchN,
  input  pwrStrobe_t strobes,
  output logic       pressEvt,
  output logic       powerEn,
  output logic       offReq,
  output logic       deactReq
);

  localparam int CW = (DEBOUNCE_CYCLES > 2) ? $clog2(DEBOUNCE_CYCLES) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(DEBOUNCE_CYCLES - 1);

  // input synchroniser, pressed level is 1
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   sampled;

  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[0] <= 1'b0;
          else       syncQ[0] <= ~switchN;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[gi] <= 1'b0;
          else       syncQ[gi] <= syncQ[gi-1];
        end
      end
    end
  endgenerate

  assign sampled = syncQ[SYNC_STAGES-1];

  // debounce: count while the sample disagrees with the accepted level
  logic [CW-1:0] cnt;
  logic          levelDb;
  logic          levelPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      levelDb <= 1'b0;
    end else if (sampled == levelDb) begin
      cnt <= '0;
    end else if (cnt == CNT_LAST) begin
      cnt     <= '0;
      levelDb <= sampled;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) levelPrev <= 1'b0;
    else       levelPrev <= levelDb;
  end

  assign pressEvt = levelDb & ~levelPrev;

  // output registers driven by control strobes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      powerEn  <= 1'b0;
      offReq   <= 1'b0;
      deactReq <= 1'b0;
    end else if (strobes.clrAll) begin
      powerEn  <= 1'b0;
      offReq   <= 1'b0;
      deactReq <= 1'b0;
    end else begin
      if (strobes.setPower)  powerEn  <= 1'b1;
      if (strobes.setOffReq) offReq   <= 1'b1;
      if (strobes.setDeact)  deactReq <= 1'b1;
    end
  end

  // R8: a press event lasts one cycle only
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    pressEvt |=> !pressEvt);

  // R2: the accepted level only moves to the value the synchroniser showed
  a_r2_level_follows_input: assert property (@(posedge clk) disable iff (!rstN)
    (levelDb != levelPrev) |-> (levelDb == $past(sampled)));

  // R5: deactivation is only requested on top of a pending shutdown
  a_r5_deact_under_req: assert property (@(posedge clk) disable iff (!rstN)
    deactReq |-> (offReq && powerEn));

  // R6: with power off no request remains
  a_r6_off_is_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !powerEn |-> (!offReq && !deactReq));

endmodule

// File: rtl/pwrbtn_control.sv
module pwrbtn_control
  import pwrbtn_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pressEvt,
  input  logic       offAck,
  input  logic       deactDone,
  output pwrStrobe_t strobes,
  output pwrState_t  state
);

  pwrState_t stateNext;

  always_comb begin
    stateNext = state;
    strobes   = '0;
    unique case (state)
      ST_OFF: if (pressEvt) begin
        stateNext        = ST_ON;
        strobes.setPower = 1'b1;
      end
      ST_ON: if (pressEvt) begin
        stateNext         = ST_REQ;
        strobes.setOffReq = 1'b1;
      end
      ST_REQ: if (offAck) begin
        stateNext        = ST_DEACT;
        strobes.setDeact = 1'b1;
      end
      ST_DEACT: if (deactDone) begin
        stateNext      = ST_OFF;
        strobes.clrAll = 1'b1;
      end
      default: stateNext = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_OFF;
    else       state <= stateNext;
  end

  // R9: at most one strobe per cycle
  a_r9_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes));

  // R9: an unacknowledged request stays pending whatever the switch does
  a_r9_req_waits: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_REQ && !offAck) |=> (state == ST_REQ));

  // R6: completion returns the controller to off
  a_r6_done_to_off: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DEACT && deactDone) |=> (state == ST_OFF));

  // R9: while on, acknowledge alone changes nothing
  a_r9_on_holds: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ON && !pressEvt) |=> (state == ST_ON));

endmodule

// File: rtl/pwrbtn_ctrl.sv
module pwrbtn_ctrl
  import pwrbtn_pkg::*;
#(
  parameter int DEBOUNCE_CYCLES = 1024,
  parameter int SYNC_STAGES     = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic switchN,
  input  logic offAck,
  input  logic deactDone,
  output logic powerEn,
  output logic offReq,
  output logic deactReq
);

  pwrStrobe_t strobes;
  pwrState_t  state;
  logic       pressEvt;

  pwrbtn_datapath #(
    .DEBOUNCE_CYCLES(DEBOUNCE_CYCLES),
    .SYNC_STAGES    (SYNC_STAGES)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .switchN (switchN),
    .strobes (strobes),
    .pressEvt(pressEvt),
    .powerEn (powerEn),
    .offReq  (offReq),
    .deactReq(deactReq)
  );

  pwrbtn_control u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .pressEvt (pressEvt),
    .offAck   (offAck),
    .deactDone(deactDone),
    .strobes  (strobes),
    .state    (state)
  );

  // R3: power comes up only out of the off state on a press
  a_r3_power_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(powerEn) |-> ($past(state) == ST_OFF && $past(pressEvt)));

  // R6: power drops only on deactivation completion
  a_r6_power_fall: assert property (@(posedge clk) disable iff (!rstN)
    $fell(powerEn) |-> ($past(deactDone) && $past(deactReq)));

  // R4: a shutdown request needs a press while on
  a_r4_req_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(offReq) |-> ($past(pressEvt) && $past(powerEn)));

  // R5: deactivation follows an acknowledged request
  a_r5_deact_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(deactReq) |-> ($past(offAck) && $past(offReq)));

endmodule

// File: tb/pwrbtn_ctrl_test.sv
module pwrbtn_ctrl_test;

  localparam int DB = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic switchN = 1'b1;
  logic hostAck = 1'b0;
  logic tieAck = 1'b0;
  logic deactDone = 1'b0;
  logic offAckIn;
  logic powerEn, offReq, deactReq;

  int checks = 0;
  int fails = 0;
  int expSt = 0;  // 0 off, 1 on, 2 request, 3 deactivating
  bit done = 1'b0;

  always #10 clk = ~clk;

  assign offAckIn = tieAck ? offReq : hostAck;

  pwrbtn_ctrl #(.DEBOUNCE_CYCLES(DB)) uut (
    .clk(clk), .rstN(rstN), .switchN(switchN), .offAck(offAckIn),
    .deactDone(deactDone), .powerEn(powerEn), .offReq(offReq),
    .deactReq(deactReq)
  );

  function automatic logic [2:0] expOut(int st);
    case (st)
      0: return 3'b000;
      1: return 3'b100;
      2: return 3'b110;
      default: return 3'b111;
    endcase
  endfunction

  function automatic int afterPress(int st);
    if (st == 0) return 1;
    if (st == 1) return 2;
    return st;
  endfunction

  task automatic waitN(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [2:0] exp);
    logic [2:0] act;
    act = {powerEn, offReq, deactReq};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: outputs got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic doPress();
    switchN = 1'b0; waitN(DB + 8);
    switchN = 1'b1; waitN(DB + 8);
    expSt = afterPress(expSt);
  endtask

  task automatic doBounce(int bursts);
    for (int b = 0; b < bursts; b++) begin
      switchN = 1'b0; waitN(1 + ($urandom % (DB - 4)));
      switchN = 1'b1; waitN(1 + ($urandom % 4));
    end
    waitN(DB + 4);
  endtask

  task automatic pulseAck();
    hostAck = 1'b1; waitN(1); hostAck = 1'b0; waitN(1);
    if (expSt == 2) expSt = 3;
  endtask

  task automatic pulseDone();
    deactDone = 1'b1; waitN(1); deactDone = 1'b0; waitN(1);
    if (expSt == 3) expSt = 0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    waitN(3);
    chk("R1", 3'b000);
    rstN = 1'b1;
    waitN(2);
    chk("R1", 3'b000);

    // R2: bounce shorter than the period is ignored
    doBounce(12);
    chk("R2", 3'b000);

    // R2: no response before the debounce period elapses
    switchN = 1'b0; waitN(DB - 1);
    chk("R2", 3'b000);
    waitN(9);
    chk("R3", 3'b100);
    // R8: keep holding, no second press
    waitN(3 * DB);
    chk("R8", 3'b100);
    // R8: short release glitch while held
    switchN = 1'b1; waitN(DB / 2);
    switchN = 1'b0; waitN(2 * DB);
    chk("R8", 3'b100);
    switchN = 1'b1; waitN(DB + 8);
    expSt = 1;

    // R9: ack and done while simply on
    pulseAck(); chk("R9", 3'b100);
    pulseDone(); chk("R9", 3'b100);

    doPress(); chk("R4", 3'b110);
    pulseDone(); chk("R9", 3'b110);
    doPress(); chk("R9", 3'b110);
    pulseAck(); chk("R5", 3'b111);
    waitN(5); chk("R5", 3'b111);
    doPress(); chk("R9", 3'b111);
    pulseDone(); chk("R6", 3'b000);
    pulseAck(); chk("R9", 3'b000);

    // R7: acknowledge tied to the request
    tieAck = 1'b1;
    doPress(); chk("R3", 3'b100);
    doPress(); expSt = 3; chk("R7", 3'b111);
    pulseDone(); chk("R7", 3'b000);
    tieAck = 1'b0;

    // random mix
    for (int i = 0; i < 250; i++) begin
      int sel;
      sel = $urandom % 5;
      case (sel)
        0, 1: begin doPress(); chk("R3/R4 random press", expOut(expSt)); end
        2: begin doBounce(1 + ($urandom % 4)); chk("R2 random bounce", expOut(expSt)); end
        3: begin pulseAck(); chk("R5 random ack", expOut(expSt)); end
        default: begin pulseDone(); chk("R6 random done", expOut(expSt)); end
      endcase
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: state got running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule